// File: doc/BRIEF.md
# Linked-Segment Command Queue Fetcher

This block feeds a consumer with fixed-size commands that software has placed in memory as a chain of linked buffer segments. Software first sets the queue up with a segment-aligned start pointer, a segment length counted in 64-bit words and the number of the free list that will take back used segments. After that it announces new commands by writing a doorbell value. The fetcher keeps a running count of announced commands that it has not yet handed out. Whenever that count is non-zero, it reads memory one word at a time over a request/response port and gathers eight data words into one command. It presents the command on a valid/ready output.

Inside every segment the final word is not command data. It carries the address of the following segment. When the fetcher reaches that word it jumps to the new segment and issues a one-cycle release of the old segment to the chosen free list. A command may start in one segment and finish in the next. The block also counts handed-out commands, raises a sticky flag if the doorbell count overflows, and shows whether the fetch machine is active. Reconfiguration is allowed only while the doorbell count is zero.

Top module: `chain_cmd_fetch`

## Requirements
- R1: While reset is asserted and after it is released, with no stimulus applied, the doorbell count, overflow flag, issued count, memory request valid, command valid, release valid and busy outputs are all zero.
- R2: A configuration write clears the issued count to zero. The first memory request after it targets byte address {cfg_ptr, 7'b0}, which is word 0 of the new start segment.
- R3: Words are requested at consecutive 8-byte addresses. Eight data words in request order form one command, and the k-th word occupies ins_data bits [64k+63:64k].
- R4: The word at index size-1 of each segment is a link. Its bits 39:7 become the new segment pointer, and reading resumes at word 0 there. A link word never appears in command data, and a command may span two segments.
- R5: One cycle after a link word is returned, free_valid pulses for exactly one cycle, with free_ptr set to the exhausted segment's pointer and free_pool set to the configured 3-bit pool number.
- R6: The doorbell count increases by db_val on a doorbell write and decreases by one on each command handshake (ins_valid and ins_ready both high). When both happen in one cycle, both take effect.
- R7: While the doorbell count is zero, the block issues no memory request, does not assert ins_valid and keeps q_busy low.
- R8: If a doorbell write would carry the 20-bit count beyond 0xFFFFF, db_ovf is set and stays set, and the count keeps the low 20 bits of the sum. Reaching exactly 0xFFFFF does not set db_ovf.
- R9: The 32-bit issued count increases by one on each command handshake.
- R10: Once ins_valid is high, it stays high with ins_data unchanged until ins_ready is seen.
- R11: A memory request keeps its valid and address steady until mem_req_ready is seen. No new request is raised until the response to the previous one has returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_ptr | input | 33 | Start segment pointer, byte address bits 39:7 |
| cfg_size | input | 13 | Segment length in 64-bit words (at least 2) |
| cfg_pool | input | 3 | Free list number for released segments |
| db_wr | input | 1 | Doorbell write strobe |
| db_val | input | 20 | Number of commands added by a doorbell write |
| mem_req_valid | output | 1 | Word read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 40 | Byte address of the requested word |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data |
| ins_valid | output | 1 | Command available |
| ins_ready | input | 1 | Consumer takes the command |
| ins_data | output | 512 | Eight-word command, word 0 in the low bits |
| free_valid | output | 1 | Segment release pulse |
| free_ptr | output | 33 | Pointer of the released segment |
| free_pool | output | 3 | Free list receiving the segment |
| db_count | output | 20 | Outstanding doorbell count |
| db_ovf | output | 1 | Sticky doorbell overflow flag |
| issue_cnt | output | 32 | Commands handed out since the last configuration |
| q_busy | output | 1 | Fetch machine is active |

## Verification
If the segment pointer or the word index goes wrong, the very next memory request shows a wrong address, one cycle after the previous response. If a link word is mishandled, the error also shows up in the release pulse and in command data at the following handshake. A fault in the doorbell arithmetic shows in db_count on the first cycle after the write or handshake. A fetch that ignores a zero count shows a request or ins_valid in that same cycle. The reference model follows the chain walk and the counters from port activity alone and compares every clock, so each of these faults is reported within a few cycles.

// File: rtl/qf_pkg.sv
`timescale 1ns/1ps
package qf_pkg;

  // States of the word-by-word fetch machine
  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_REQ  = 2'd1,
    FS_WAIT = 2'd2,
    FS_HOLD = 2'd3
  } fetch_st_e;

endpackage

// File: rtl/qf_doorbell.sv
`timescale 1ns/1ps
// Outstanding-command counter, sticky overflow and issued-command counter
module qf_doorbell #(
  parameter int DB_W  = 20,
  parameter int ISS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             db_wr,
  input  logic [DB_W-1:0]  db_val,
  input  logic             take,
  input  logic             cfg_wr,
  output logic [DB_W-1:0]  db_count,
  output logic             db_ovf,
  output logic [ISS_W-1:0] issue_cnt
);

  localparam int SUM_W = DB_W + 1;

  logic [DB_W-1:0]  cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic [ISS_W-1:0] iss_q, iss_d;
  logic [SUM_W-1:0] sum;
  logic             cnt_en, iss_en;

  always_comb begin
    sum    = {1'b0, cnt_q}
           + (db_wr ? {1'b0, db_val} : {SUM_W{1'b0}})
           - {{DB_W{1'b0}}, take};
    cnt_d  = sum[DB_W-1:0];
    ovf_d  = ovf_q | sum[DB_W];
    cnt_en = db_wr | take;
    iss_d  = cfg_wr ? {ISS_W{1'b0}} : iss_q + ISS_W'(1);
    iss_en = cfg_wr | take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
      iss_q <= '0;
    end else begin
      if (cnt_en) begin
        cnt_q <= cnt_d;
        ovf_q <= ovf_d;
      end
      if (iss_en) iss_q <= iss_d;
    end
  end

  assign db_count  = cnt_q;
  assign db_ovf    = ovf_q;
  assign issue_cnt = iss_q;

endmodule

// File: rtl/qf_asm.sv
`timescale 1ns/1ps
// Command assembly buffer: one register per word slot
module qf_asm #(
  parameter int WORD_W    = 64,
  parameter int INS_WORDS = 8
) (
  input  logic                        clk,
  input  logic                        we,
  input  logic [$clog2(INS_WORDS)-1:0] idx,
  input  logic [WORD_W-1:0]           wdata,
  output logic [WORD_W*INS_WORDS-1:0] ins_data
);

  localparam int SLOT_W = $clog2(INS_WORDS);

  for (genvar g = 0; g < INS_WORDS; g++) begin : g_slot
    logic [WORD_W-1:0] slot_q;
    logic              slot_en;

    assign slot_en = we && (idx == SLOT_W'(g));

    always_ff @(posedge clk) begin
      if (slot_en) slot_q <= wdata;
    end

    assign ins_data[g*WORD_W +: WORD_W] = slot_q;
  end

endmodule

// File: rtl/qf_walker.sv
`timescale 1ns/1ps
// Segment walker: issues word reads, follows links, releases segments
module qf_walker
  import qf_pkg::*;
#(
  parameter int ADDR_W    = 40,
  parameter int ALIGN     = 7,
  parameter int SIZE_W    = 13,
  parameter int POOL_W    = 3,
  parameter int WORD_W    = 64,
  parameter int INS_WORDS = 8,
  localparam int PTR_W    = ADDR_W - ALIGN,
  localparam int SLOT_W   = $clog2(INS_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [PTR_W-1:0]  cfg_ptr,
  input  logic [SIZE_W-1:0] cfg_size,
  input  logic [POOL_W-1:0] cfg_pool,
  input  logic              have_work,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [PTR_W-1:0]  rsp_link,
  output logic              slot_we,
  output logic [SLOT_W-1:0] slot_idx,
  output logic              ins_valid,
  input  logic              ins_ready,
  output logic              free_valid,
  output logic [PTR_W-1:0]  free_ptr,
  output logic [POOL_W-1:0] free_pool,
  output logic              busy
);

  localparam int BYTE_SH = $clog2(WORD_W / 8);

  fetch_st_e         st_q, st_d;
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic [SIZE_W-1:0] widx_q, widx_d;
  logic [SIZE_W-1:0] size_q;
  logic [POOL_W-1:0] pool_q;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              fr_v_q, fr_v_d;
  logic [PTR_W-1:0]  fr_ptr_q;
  logic [POOL_W-1:0] fr_pool_q;
  logic              at_link;
  logic              link_take;
  logic              ptr_en;

  assign at_link   = (widx_q == SIZE_W'(size_q - SIZE_W'(1)));
  assign link_take = (st_q == FS_WAIT) && mem_rsp_valid && at_link;
  assign ptr_en    = cfg_wr | link_take;

  always_comb begin
    st_d    = st_q;
    ptr_d   = ptr_q;
    widx_d  = widx_q;
    slot_d  = slot_q;
    fr_v_d  = 1'b0;
    slot_we = 1'b0;
    unique case (st_q)
      FS_IDLE: if (have_work) st_d = FS_REQ;
      FS_REQ:  if (mem_req_ready) st_d = FS_WAIT;
      FS_WAIT: begin
        if (mem_rsp_valid) begin
          if (at_link) begin
            ptr_d  = rsp_link;
            widx_d = '0;
            fr_v_d = 1'b1;
            st_d   = FS_REQ;
          end else begin
            slot_we = 1'b1;
            widx_d  = widx_q + SIZE_W'(1);
            if (slot_q == SLOT_W'(INS_WORDS - 1)) begin
              slot_d = '0;
              st_d   = FS_HOLD;
            end else begin
              slot_d = slot_q + SLOT_W'(1);
              st_d   = FS_REQ;
            end
          end
        end
      end
      FS_HOLD: if (ins_ready) st_d = FS_IDLE;
      default: st_d = FS_IDLE;
    endcase
    if (cfg_wr) begin
      st_d   = FS_IDLE;
      ptr_d  = cfg_ptr;
      widx_d = '0;
      slot_d = '0;
      fr_v_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= FS_IDLE;
      ptr_q     <= '0;
      widx_q    <= '0;
      size_q    <= '0;
      pool_q    <= '0;
      slot_q    <= '0;
      fr_v_q    <= 1'b0;
      fr_ptr_q  <= '0;
      fr_pool_q <= '0;
    end else begin
      st_q   <= st_d;
      widx_q <= widx_d;
      slot_q <= slot_d;
      fr_v_q <= fr_v_d;
      if (ptr_en) ptr_q <= ptr_d;
      if (cfg_wr) begin
        size_q <= cfg_size;
        pool_q <= cfg_pool;
      end
      if (link_take) begin
        fr_ptr_q  <= ptr_q;
        fr_pool_q <= pool_q;
      end
    end
  end

  assign mem_req_valid = (st_q == FS_REQ);
  assign mem_req_addr  = {ptr_q, {ALIGN{1'b0}}} + (ADDR_W'(widx_q) << BYTE_SH);
  assign slot_idx      = slot_q;
  assign ins_valid     = (st_q == FS_HOLD);
  assign free_valid    = fr_v_q;
  assign free_ptr      = fr_ptr_q;
  assign free_pool     = fr_pool_q;
  assign busy          = (st_q != FS_IDLE);

endmodule

// File: rtl/chain_cmd_fetch.sv
`timescale 1ns/1ps
// Top: linked-segment command queue fetcher
module chain_cmd_fetch #(
  parameter int ADDR_W    = 40,
  parameter int ALIGN     = 7,
  parameter int SIZE_W    = 13,
  parameter int POOL_W    = 3,
  parameter int DB_W      = 20,
  parameter int ISS_W     = 32,
  parameter int WORD_W    = 64,
  parameter int INS_WORDS = 8,
  localparam int PTR_W    = ADDR_W - ALIGN,
  localparam int INS_W    = WORD_W * INS_WORDS,
  localparam int SLOT_W   = $clog2(INS_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [PTR_W-1:0]  cfg_ptr,
  input  logic [SIZE_W-1:0] cfg_size,
  input  logic [POOL_W-1:0] cfg_pool,
  input  logic              db_wr,
  input  logic [DB_W-1:0]   db_val,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data,
  output logic              ins_valid,
  input  logic              ins_ready,
  output logic [INS_W-1:0]  ins_data,
  output logic              free_valid,
  output logic [PTR_W-1:0]  free_ptr,
  output logic [POOL_W-1:0] free_pool,
  output logic [DB_W-1:0]   db_count,
  output logic              db_ovf,
  output logic [ISS_W-1:0]  issue_cnt,
  output logic              q_busy
);

  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  logic              take;
  logic              slot_we;
  logic [SLOT_W-1:0] slot_idx;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  assign take = ins_valid & ins_ready;

  qf_doorbell #(
    .DB_W  (DB_W),
    .ISS_W (ISS_W)
  ) u_db (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .db_wr     (db_wr),
    .db_val    (db_val),
    .take      (take),
    .cfg_wr    (cfg_wr),
    .db_count  (db_count),
    .db_ovf    (db_ovf),
    .issue_cnt (issue_cnt)
  );

  qf_walker #(
    .ADDR_W    (ADDR_W),
    .ALIGN     (ALIGN),
    .SIZE_W    (SIZE_W),
    .POOL_W    (POOL_W),
    .WORD_W    (WORD_W),
    .INS_WORDS (INS_WORDS)
  ) u_walk (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .cfg_wr        (cfg_wr),
    .cfg_ptr       (cfg_ptr),
    .cfg_size      (cfg_size),
    .cfg_pool      (cfg_pool),
    .have_work     (db_count != '0),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .rsp_link      (mem_rsp_data[ADDR_W-1:ALIGN]),
    .slot_we       (slot_we),
    .slot_idx      (slot_idx),
    .ins_valid     (ins_valid),
    .ins_ready     (ins_ready),
    .free_valid    (free_valid),
    .free_ptr      (free_ptr),
    .free_pool     (free_pool),
    .busy          (q_busy)
  );

  qf_asm #(
    .WORD_W    (WORD_W),
    .INS_WORDS (INS_WORDS)
  ) u_asm (
    .clk      (clk),
    .we       (slot_we),
    .idx      (slot_idx),
    .wdata    (mem_rsp_data),
    .ins_data (ins_data)
  );

endmodule

// File: rtl/qf_chk.sv
`timescale 1ns/1ps
// Protocol and counter checks, bound onto the fetcher top
module qf_chk #(
  parameter int ADDR_W = 40,
  parameter int INS_W  = 512,
  parameter int DB_W   = 20,
  parameter int ISS_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid,
  input logic              ins_valid,
  input logic              ins_ready,
  input logic [INS_W-1:0]  ins_data,
  input logic              free_valid,
  input logic [DB_W-1:0]   db_count,
  input logic              db_ovf,
  input logic [ISS_W-1:0]  issue_cnt,
  input logic              q_busy
);

  // R10
  hold_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && !ins_ready |=> ins_valid && $stable(ins_data));

  // R11
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R11
  one_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !mem_req_valid);

  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    db_count == '0 |-> !mem_req_valid && !ins_valid && !q_busy);

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    db_ovf |=> db_ovf);

  // R5
  free_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_valid |-> $past(mem_rsp_valid));

  // R5
  free_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_valid |=> !free_valid);

  // R9
  issue_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && ins_ready && !cfg_wr |=> issue_cnt == ISS_W'($past(issue_cnt) + 1));

endmodule

bind chain_cmd_fetch qf_chk #(
  .ADDR_W (ADDR_W),
  .INS_W  (WORD_W * INS_WORDS),
  .DB_W   (DB_W),
  .ISS_W  (ISS_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_wr        (cfg_wr),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .ins_valid     (ins_valid),
  .ins_ready     (ins_ready),
  .ins_data      (ins_data),
  .free_valid    (free_valid),
  .db_count      (db_count),
  .db_ovf        (db_ovf),
  .issue_cnt     (issue_cnt),
  .q_busy        (q_busy)
);

// File: tb/sim_chain_cmd_fetch.sv
`timescale 1ns/1ps
module sim_chain_cmd_fetch;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic          cfg_wr;
  logic [32:0]   cfg_ptr;
  logic [12:0]   cfg_size;
  logic [2:0]    cfg_pool;
  logic          db_wr;
  logic [19:0]   db_val;
  logic          mem_req_valid, mem_req_ready;
  logic [39:0]   mem_req_addr;
  logic          mem_rsp_valid;
  logic [63:0]   mem_rsp_data;
  logic          ins_valid, ins_ready;
  logic [511:0]  ins_data;
  logic          free_valid;
  logic [32:0]   free_ptr;
  logic [2:0]    free_pool;
  logic [19:0]   db_count;
  logic          db_ovf;
  logic [31:0]   issue_cnt;
  logic          q_busy;

  chain_cmd_fetch u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_ptr(cfg_ptr),
    .cfg_size(cfg_size), .cfg_pool(cfg_pool), .db_wr(db_wr), .db_val(db_val),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_data(ins_data), .free_valid(free_valid), .free_ptr(free_ptr),
    .free_pool(free_pool), .db_count(db_count), .db_ovf(db_ovf),
    .issue_cnt(issue_cnt), .q_busy(q_busy)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  int cycle = 0;

  // reference model state
  int          m_db  = 0;
  bit          m_ovf = 0;
  logic [31:0] m_iss = '0;

  logic [63:0]  mem [logic [39:0]];
  logic [39:0]  exp_addr[$];
  string        exp_addr_tag[$];
  logic [511:0] exp_ins[$];
  string        exp_ins_tag[$];
  logic [35:0]  exp_free[$];

  int           pend = 0;
  logic [63:0]  pend_data;
  int           ins_mode = 1;   // 0 never ready, 1 always ready, 2 alternate
  bit           first_req = 0;
  logic [39:0]  first_addr;
  bit           prev_req_wait = 0;
  logic [39:0]  prev_addr;
  bit           prev_hold = 0;
  logic [511:0] prev_data;

  task automatic chk(input bit ok, input string req,
                     input logic [511:0] act, input logic [511:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    bit hs;
    int s;
    logic [39:0] ea;
    logic [35:0] ef;
    @(negedge clk);
    cycle++;
    chk(db_count == 20'(m_db), "R6", db_count, 20'(m_db));
    chk(db_ovf == m_ovf, "R8", db_ovf, m_ovf);
    chk(issue_cnt == m_iss, "R9", issue_cnt, m_iss);
    if (m_db == 0)
      chk(!mem_req_valid && !ins_valid && !q_busy, "R7",
          {mem_req_valid, ins_valid, q_busy}, 3'b000);
    if (prev_req_wait)
      chk(mem_req_valid && mem_req_addr == prev_addr, "R11", mem_req_addr, prev_addr);
    if (prev_hold)
      chk(ins_valid && ins_data == prev_data, "R10", ins_data, prev_data);
    if (free_valid) begin
      if (exp_free.size() == 0) chk(1'b0, "R5", {free_ptr, free_pool}, 0);
      else begin
        ef = exp_free.pop_front();
        chk({free_ptr, free_pool} == ef, "R5", {free_ptr, free_pool}, ef);
      end
    end
    // memory side
    mem_rsp_valid = 1'b0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = pend_data;
      end
    end
    mem_req_ready = (cycle % 3) != 1;
    if (mem_req_valid && mem_req_ready) begin
      if (first_req) begin
        chk(mem_req_addr == first_addr, "R2", mem_req_addr, first_addr);
        first_req = 0;
      end
      if (exp_addr.size() == 0) chk(1'b0, "R3", mem_req_addr, 0);
      else begin
        ea = exp_addr.pop_front();
        chk(mem_req_addr == ea, exp_addr_tag.pop_front(), mem_req_addr, ea);
      end
      pend_data = mem.exists(mem_req_addr) ? mem[mem_req_addr] : 64'hDEAD_BEEF_DEAD_BEEF;
      pend = 2 + (cycle % 2);
    end
    // command side
    ins_ready = (ins_mode == 1) || (ins_mode == 2 && cycle[0]);
    hs = ins_valid && ins_ready;
    if (hs) begin
      if (exp_ins.size() == 0) chk(1'b0, "R3", ins_data, 0);
      else chk(ins_data == exp_ins[0], exp_ins_tag[0], ins_data, exp_ins[0]);
      if (exp_ins.size() != 0) begin
        void'(exp_ins.pop_front());
        void'(exp_ins_tag.pop_front());
      end
    end
    prev_req_wait = mem_req_valid && !mem_req_ready;
    prev_addr     = mem_req_addr;
    prev_hold     = ins_valid && !ins_ready;
    prev_data     = ins_data;
    // model update for the coming edge
    s = m_db + (db_wr ? int'(db_val) : 0) - (hs ? 1 : 0);
    if (s > 32'hFFFFF) m_ovf = 1;
    m_db  = s & 32'hFFFFF;
    m_iss = cfg_wr ? 32'd0 : m_iss + (hs ? 32'd1 : 32'd0);
    @(posedge clk);
    #1;
  endtask

  task automatic build(input logic [32:0] p0, input int size,
                       input logic [2:0] pool, input int nseg);
    logic [63:0] words[$];
    int          segof[$];
    logic [511:0] ins;
    exp_addr.delete(); exp_addr_tag.delete();
    exp_ins.delete();  exp_ins_tag.delete();
    exp_free.delete();
    for (int k = 0; k < nseg; k++) begin
      logic [32:0] p, pn;
      logic [39:0] base, a;
      p    = p0 + 33'(k * 37);
      pn   = p0 + 33'((k + 1) * 37);
      base = {p, 7'b0};
      for (int w = 0; w < size - 1; w++) begin
        a = base + 40'(w * 8);
        mem[a] = {24'hC3A5E0, a};
        exp_addr.push_back(a); exp_addr_tag.push_back("R3");
        words.push_back({24'hC3A5E0, a});
        segof.push_back(k);
      end
      a = base + 40'((size - 1) * 8);
      mem[a] = {24'h0, pn, 7'h5A};
      exp_addr.push_back(a); exp_addr_tag.push_back("R4");
      exp_free.push_back({p, pool});
    end
    for (int i = 0; i + 8 <= words.size(); i += 8) begin
      for (int j = 0; j < 8; j++) ins[64*j +: 64] = words[i + j];
      exp_ins.push_back(ins);
      exp_ins_tag.push_back(segof[i] != segof[i + 7] ? "R4" : "R3");
    end
  endtask

  task automatic configure(input logic [32:0] p, input int size,
                           input logic [2:0] pool, input int nseg);
    build(p, size, pool, nseg);
    cfg_wr = 1; cfg_ptr = p; cfg_size = 13'(size); cfg_pool = pool;
    first_req = 1; first_addr = {p, 7'b0};
    cyc();
    cfg_wr = 0;
    chk(issue_cnt == 32'd0, "R2", issue_cnt, 0);
  endtask

  task automatic doorbell(input logic [19:0] v);
    db_wr = 1; db_val = v;
    cyc();
    db_wr = 0; db_val = '0;
  endtask

  task automatic drain(input int maxc);
    for (int i = 0; i < maxc && m_db != 0; i++) cyc();
    chk(m_db == 0, "R6", 20'(m_db), 0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_wr = 0; cfg_ptr = '0; cfg_size = '0; cfg_pool = '0;
    db_wr = 0; db_val = '0; mem_req_ready = 0; mem_rsp_valid = 0;
    mem_rsp_data = '0; ins_ready = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 during reset
    chk({db_count, db_ovf, issue_cnt, mem_req_valid, ins_valid, free_valid, q_busy} == '0,
        "R1", {db_count, db_ovf, issue_cnt}, 0);
    @(posedge clk); #1;
    rst_n = 1;
    repeat (4) cyc();
    chk({db_count, db_ovf, issue_cnt, mem_req_valid, ins_valid, free_valid, q_busy} == '0,
        "R1", {db_count, db_ovf, issue_cnt}, 0);

    // chain A: commands straddle segments
    configure(33'h100, 20, 3'd5, 4);
    ins_mode = 2;
    doorbell(20'd3);
    drain(500);
    ins_mode = 1;
    doorbell(20'd2);
    cyc();
    doorbell(20'd4);
    drain(800);
    chk(issue_cnt == 32'd9, "R9", issue_cnt, 9);
    // stall with zero count (R7)
    repeat (6) cyc();

    // chain B: one command per segment, same-cycle doorbell and handshake
    configure(33'h0_ABCD_0000, 9, 3'd2, 8);
    ins_mode = 0;
    doorbell(20'd1);
    for (int i = 0; i < 200 && !ins_valid; i++) cyc();
    repeat (3) cyc();
    ins_mode = 1;
    db_wr = 1; db_val = 20'd3;
    cyc();
    db_wr = 0; db_val = '0;
    chk(db_count == 20'd3, "R6", db_count, 3);
    drain(500);
    doorbell(20'd4);
    drain(500);
    chk(exp_free.size() == 1, "R5", exp_free.size(), 1);

    // chain C: shortest segments, a link after every data word
    configure(33'h1_0000_0040, 2, 3'd7, 17);
    ins_mode = 2;
    doorbell(20'd2);
    drain(800);
    chk(exp_free.size() == 2, "R5", exp_free.size(), 2);

    // chain D: doorbell overflow
    configure(33'h40, 16, 3'd0, 2);
    ins_mode = 0;
    doorbell(20'hFFFFF);
    repeat (3) cyc();
    chk(db_ovf == 1'b0 && db_count == 20'hFFFFF, "R8", {db_ovf, db_count}, 21'h0FFFFF);
    doorbell(20'd2);
    repeat (3) cyc();
    chk(db_ovf == 1'b1 && db_count == 20'd1, "R8", {db_ovf, db_count}, 21'h100001);
    ins_mode = 1;
    drain(300);
    repeat (4) cyc();
    chk(db_ovf == 1'b1, "R8", db_ovf, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule